// File: doc/BRIEF.md
# Diagonal-Difference Edge Strength Filter

This block takes a raster-ordered stream of 8-bit grayscale pixels and returns, for each accepted pixel, an edge strength taken from the 2x2 neighbourhood whose lower-right corner is that pixel. Call the pixel above-left `a`, the pixel above `b`, the pixel to the left `c` and the current pixel `d`. The strength is the larger of `|d - a|` and `|b - c|`. These are the magnitudes of the two diagonal (+1, -1) kernels, and together they act as a cheap gradient magnitude. The default frame is 385 pixels wide and 288 lines tall. A single line buffer, `WIDTH` entries deep, holds the previous line. Two registers hold the previous pixel of each row.

The input and the output are both streams with valid and start-of-frame qualifiers. A scan controller tracks the position in the frame. Its states are `ST_WAIT_SOF` (no frame open), `ST_TOP_LINE` (line 0 in progress) and `ST_BODY` (lines 1 to `HEIGHT-1`). It has these transitions:
- An accepted start-of-frame pixel enters `ST_TOP_LINE` from any state.
- The last pixel of line 0 moves `ST_TOP_LINE` to `ST_BODY`.
- The last pixel of the last line moves either active state to `ST_WAIT_SOF`.
- Reset returns to `ST_WAIT_SOF`.

Top module: `roberts_edge`

## Requirements
- R1: During and directly after reset, `out_valid`, `out_sof` and `out_pix` are all 0.
- R2: For a pixel at line r ≥ 1, column c ≥ 1 the output equals max(|d − a|, |b − c|). Here a = pixel(r−1,c−1), b = pixel(r−1,c), c = pixel(r,c−1) and d = pixel(r,c), all unsigned 8-bit values, so the result lies in 0..255.
- R3: The output is 0 for every pixel on line 0 and for every pixel in column 0.
- R4: A pixel accepted at rising edge k has its result on the outputs after edge k+1, with `out_valid` high in that cycle only. Outputs keep the input order.
- R5: `out_sof` is 1 only together with the result of the pixel that carried the start-of-frame marker.
- R6: A cycle with `in_valid` low consumes nothing. It leaves the position and the neighbourhood untouched, so a stream with gaps gives the same results as the same stream without gaps.
- R7: Valid pixels without a start marker are dropped and produce no output in two cases: before the first frame after reset, and after the `WIDTH*HEIGHT`-th pixel of a frame.
- R8: A start marker in the middle of a frame abandons that frame and restarts at line 0, column 0.
- R9: `in_sof` has no effect in a cycle where `in_valid` is low.
- R10: `out_pix` is 0 in every cycle where `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input pixel qualifier |
| in_sof | input | 1 | Marks the first pixel of a frame (qualified by `in_valid`) |
| in_pix | input | 8 | Input grayscale pixel |
| out_valid | output | 1 | Output result qualifier |
| out_sof | output | 1 | Marks the result of a frame's first pixel |
| out_pix | output | 8 | Edge strength |

## Verification
The assertions assume the following about the inputs:
- `WIDTH` and `HEIGHT` are both at least 2.
- Inputs settle away from the rising edge.
- `in_sof` is meaningful only together with `in_valid`.

Under these assumptions, one accepted pixel always yields exactly one result two stages later. The stimulus changes inputs only on falling edges and uses a 6x4 frame so that whole frames can be swept quickly. It deliberately raises `in_sof` in idle cycles and sends stray pixels outside a frame, because the block must tolerate both. Expected strengths come from a frame image the bench keeps for itself.

// File: rtl/roberts_pkg.sv
package roberts_pkg;

    typedef enum logic [1:0] {
        ST_WAIT_SOF = 2'd0,
        ST_TOP_LINE = 2'd1,
        ST_BODY     = 2'd2
    } scan_state_t;

endpackage

// File: rtl/roberts_scan_fsm.sv
module roberts_scan_fsm
    import roberts_pkg::*;
#(
    parameter int WIDTH  = 385,
    parameter int HEIGHT = 288,
    localparam int COL_W = $clog2(WIDTH),
    localparam int ROW_W = $clog2(HEIGHT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sof,
    output logic             accept,
    output logic             sof_accept,
    output logic             border,
    output logic             frame_active,
    output logic [COL_W-1:0] pos_col
);

    scan_state_t      state_q, state_d, cur_state;
    logic [COL_W-1:0] col_q, col_d;
    logic [ROW_W-1:0] row_q, row_d, pos_row;
    logic             line_end, frame_end;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_WAIT_SOF;
            col_q   <= '0;
            row_q   <= '0;
        end else begin
            state_q <= state_d;
            col_q   <= col_d;
            row_q   <= row_d;
        end
    end

    // next state and outputs
    always_comb begin
        sof_accept   = in_valid && in_sof;
        cur_state    = sof_accept ? ST_TOP_LINE : state_q;
        accept       = in_valid && (cur_state != ST_WAIT_SOF);
        pos_col      = sof_accept ? '0 : col_q;
        pos_row      = sof_accept ? '0 : row_q;
        line_end     = (pos_col == COL_W'(WIDTH - 1));
        frame_end    = line_end && (pos_row == ROW_W'(HEIGHT - 1));
        border       = (pos_col == '0) || (pos_row == '0);
        frame_active = (state_q != ST_WAIT_SOF);
        state_d      = state_q;
        col_d        = col_q;
        row_d        = row_q;
        if (accept) begin
            col_d = line_end ? '0 : pos_col + COL_W'(1);
            row_d = frame_end ? '0 : (line_end ? pos_row + ROW_W'(1) : pos_row);
            unique case (cur_state)
                ST_TOP_LINE: state_d = frame_end ? ST_WAIT_SOF
                                     : (line_end ? ST_BODY : ST_TOP_LINE);
                ST_BODY:     state_d = frame_end ? ST_WAIT_SOF : ST_BODY;
                default:     state_d = ST_WAIT_SOF;
            endcase
        end
    end

    // R8
    col_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        col_q <= COL_W'(WIDTH - 1));

    // R8
    row_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        row_q <= ROW_W'(HEIGHT - 1));

    // R7
    wait_col_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_SOF) |-> (col_q == '0 && row_q == '0));

endmodule

// File: rtl/roberts_line_buf.sv
module roberts_line_buf #(
    parameter int WIDTH  = 385,
    parameter int PIX_W  = 8,
    localparam int COL_W = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [COL_W-1:0] addr,
    input  logic [PIX_W-1:0] wdata,
    output logic [PIX_W-1:0] rdata
);

    logic [PIX_W-1:0] mem [WIDTH];

    // read returns the value written one line earlier at this column
    assign rdata = mem[addr];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[addr] <= wdata;
        end
    end

endmodule

// File: rtl/roberts_kernel.sv
module roberts_kernel #(
    parameter int PIX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             sof_accept,
    input  logic             border,
    input  logic [PIX_W-1:0] cur_pix,
    input  logic [PIX_W-1:0] up_pix,
    output logic             out_valid,
    output logic             out_sof,
    output logic [PIX_W-1:0] out_pix
);

    logic [PIX_W-1:0] up_prev, cur_prev;
    logic [PIX_W-1:0] s1_a, s1_b, s1_c, s1_d;
    logic             s1_valid, s1_sof, s1_border;
    logic [PIX_W-1:0] diag_main, diag_anti, mag;

    function automatic logic [PIX_W-1:0] absdiff(input logic [PIX_W-1:0] x,
                                                 input logic [PIX_W-1:0] y);
        return (x > y) ? x - y : y - x;
    endfunction

    // stage 1: capture the 2x2 window
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            up_prev   <= '0;
            cur_prev  <= '0;
            s1_a      <= '0;
            s1_b      <= '0;
            s1_c      <= '0;
            s1_d      <= '0;
            s1_valid  <= 1'b0;
            s1_sof    <= 1'b0;
            s1_border <= 1'b0;
        end else begin
            s1_valid <= accept;
            s1_sof   <= sof_accept;
            if (accept) begin
                s1_a      <= up_prev;
                s1_b      <= up_pix;
                s1_c      <= cur_prev;
                s1_d      <= cur_pix;
                s1_border <= border;
                up_prev   <= up_pix;
                cur_prev  <= cur_pix;
            end
        end
    end

    always_comb begin
        diag_main = absdiff(s1_d, s1_a);
        diag_anti = absdiff(s1_b, s1_c);
        mag       = (diag_main > diag_anti) ? diag_main : diag_anti;
    end

    // stage 2: registered result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
            out_pix   <= '0;
        end else begin
            out_valid <= s1_valid;
            out_sof   <= s1_valid && s1_sof;
            out_pix   <= (s1_valid && !s1_border) ? mag : '0;
        end
    end

    // R3
    border_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && border) |=> ##1 (out_pix == '0));

    // R5
    sof_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> out_valid);

endmodule

// File: rtl/roberts_edge.sv
module roberts_edge #(
    parameter int WIDTH  = 385,
    parameter int HEIGHT = 288,
    parameter int PIX_W  = 8,
    localparam int COL_W = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic [PIX_W-1:0] in_pix,
    output logic             out_valid,
    output logic             out_sof,
    output logic [PIX_W-1:0] out_pix
);

    logic             accept, sof_accept, border, frame_active;
    logic [COL_W-1:0] pos_col;
    logic [PIX_W-1:0] up_pix;

    roberts_scan_fsm #(.WIDTH(WIDTH), .HEIGHT(HEIGHT)) i_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_sof       (in_sof),
        .accept       (accept),
        .sof_accept   (sof_accept),
        .border       (border),
        .frame_active (frame_active),
        .pos_col      (pos_col)
    );

    roberts_line_buf #(.WIDTH(WIDTH), .PIX_W(PIX_W)) i_line (
        .clk   (clk),
        .wr_en (accept),
        .addr  (pos_col),
        .wdata (in_pix),
        .rdata (up_pix)
    );

    roberts_kernel #(.PIX_W(PIX_W)) i_kernel (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .sof_accept (sof_accept),
        .border     (border),
        .cur_pix    (in_pix),
        .up_pix     (up_pix),
        .out_valid  (out_valid),
        .out_sof    (out_sof),
        .out_pix    (out_pix)
    );

    // R4
    latency_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_sof || frame_active)) |=> ##1 out_valid);

    // R6
    gap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ##1 !out_valid);

    // R7
    wait_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_active && !in_sof) |=> ##1 !out_valid);

    // R10
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_pix == '0));

endmodule

// File: tb/test_roberts_edge.sv
module test_roberts_edge;

    localparam int W = 6;
    localparam int H = 4;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       in_valid, in_sof;
    logic [7:0] in_pix;
    logic       out_valid, out_sof;
    logic [7:0] out_pix;

    always #4 clk = ~clk;

    roberts_edge #(.WIDTH(W), .HEIGHT(H), .PIX_W(8)) i_roberts_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sof    (in_sof),
        .in_pix    (in_pix),
        .out_valid (out_valid),
        .out_sof   (out_sof),
        .out_pix   (out_pix)
    );

    int    n_checks = 0;
    int    n_fails  = 0;
    int    img [H][W];
    bit    m_active = 1'b0;
    int    mcol = 0, mrow = 0;
    string ctx = "R4";
    string data_tag = "";
    bit    e1_v = 0, e1_s = 0, e2_v = 0, e2_s = 0;
    int    e1_p = 0, e2_p = 0;
    string e1_r = "R1", e2_r = "R1";

    function automatic int iabs(input int x);
        return (x < 0) ? -x : x;
    endfunction

    task automatic compare();
        bit bad;
        n_checks++;
        bad = (out_valid !== e2_v) || (out_sof !== e2_s) || (out_pix !== 8'(e2_p));
        if (bad) begin
            n_fails++;
            $display("FAIL %s: actual v=%0d s=%0d p=%0d expected v=%0d s=%0d p=%0d",
                     e2_r, out_valid, out_sof, out_pix, e2_v, e2_s, e2_p);
        end
    endtask

    task automatic step(input bit v, input bit s, input int p);
        @(negedge clk);
        compare();
        e2_v = e1_v; e2_s = e1_s; e2_p = e1_p; e2_r = e1_r;
        e1_v = 0; e1_s = 0; e1_p = 0; e1_r = ctx;
        if (v && s) begin
            m_active = 1'b1; mcol = 0; mrow = 0;
        end
        if (v && m_active) begin
            img[mrow][mcol] = p & 255;
            e1_v = 1; e1_s = s;
            if (mrow == 0 || mcol == 0) begin
                e1_r = "R3";
            end else begin
                int dm, da;
                dm = iabs(img[mrow][mcol] - img[mrow-1][mcol-1]);
                da = iabs(img[mrow-1][mcol] - img[mrow][mcol-1]);
                e1_p = (dm > da) ? dm : da;
                e1_r = "R2";
            end
            if (data_tag != "") e1_r = data_tag;
            if (s) e1_r = "R5";
            if (mcol == W - 1) begin
                mcol = 0;
                if (mrow == H - 1) m_active = 1'b0;
                else mrow++;
            end else begin
                mcol++;
            end
        end
        in_valid = v; in_sof = s; in_pix = 8'(p);
    endtask

    function automatic int pat(input int f, input int r, input int c);
        unique case (f)
            0: return (r * W + c) * 11;
            1: return ((r + c) % 2) ? 255 : 0;
            2: return (c % 2) ? 200 : 17;
            3: return (r % 2) ? 0 : 255;
            4: return (r * 73 + c * 151 + 29) * 2654435 / 7;
            default: return 255 - r * 40 - c * 9;
        endcase
    endfunction

    task automatic send_frame(input int f, input bit gaps);
        for (int r = 0; r < H; r++) begin
            for (int c = 0; c < W; c++) begin
                step(1'b1, (r == 0 && c == 0), pat(f, r, c) & 255);
                if (gaps) begin
                    ctx = ((r + c) % 2) ? "R9" : "R6";
                    step(1'b0, ((r + c) % 2) == 1, 99);
                    ctx = "R4";
                end
            end
        end
    endtask

    initial begin
        #(8 * 200000);
        n_fails++;
        $display("FAIL R4: watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_sof = 1'b0; in_pix = 8'd0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            n_checks++;
            if (out_valid !== 1'b0 || out_sof !== 1'b0 || out_pix !== 8'd0) begin
                n_fails++;
                $display("FAIL R1: actual v=%0d s=%0d p=%0d expected 0 0 0",
                         out_valid, out_sof, out_pix);
            end
        end
        rst_n = 1'b1;
        ctx = "R1";
        step(1'b0, 1'b0, 0);
        step(1'b0, 1'b0, 0);
        // R7: stray pixels before any frame
        ctx = "R7";
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 40 + i * 30);
        // R9: start marker without valid
        ctx = "R9";
        step(1'b0, 1'b1, 7);
        step(1'b1, 1'b0, 8);
        ctx = "R4";
        // R2 R3 R5: sweep of pattern frames, back to back
        for (int f = 0; f < 6; f++) send_frame(f, 1'b0);
        // R6 R9: frame with idle gaps, some with in_sof raised
        send_frame(4, 1'b1);
        // R7: stray pixels after the frame closed
        ctx = "R7";
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 250 - i * 60);
        ctx = "R4";
        // R8: abandoned partial frame, then restart
        for (int i = 0; i < W + 2; i++) step(1'b1, (i == 0), (i * 97) & 255);
        data_tag = "R8";
        send_frame(1, 1'b0);
        data_tag = "";
        ctx = "R10";
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule